// File: doc/BRIEF.md
# Page Permission and Protection-Key Checker

This block sits at the end of a page-table walk. It receives the attributes that the walk has already merged across all levels: the user bit, the writable bit and the no-execute bit. It also receives the 4-bit protection key of the leaf entry and the context of the access: its privilege, its type, the paging mode enables and the two key-rights registers. From these it works out the read, write and execute rights that the resulting translation may carry. If the requested access is not allowed, it instead reports a page fault together with its error code.

For 64-bit addressing, the block also checks whether the virtual address is canonical. A non-canonical address is reported as a general-protection fault, and this fault takes priority over every paging check. Memory is never touched. The result is registered, and each request strobe produces exactly one result strobe one clock later.

Top module: `page_rights_checker`

## Requirements
- R1: A user access (`acc_priv`=0) to a page whose `pg_user` is 0 is a page fault with the present bit set. This check wins over all key and rights checks, so the key bit (error code bit 5) is never set for it.
- R2: Read is granted unless the privilege is supervisor-with-user-access-blocked (`acc_priv`=2) and `pg_user` is 1.
- R3: When read is granted, write is also granted if `pg_write` is 1, or if the access is supervisor (`acc_priv`=1 or 2) and `mode_wp` is 0.
- R4: Execute is granted when `pg_nx` is 0, and either the access is user or the case `mode_smep`=1 with `pg_user`=1 does not apply.
- R5: A user page (`pg_user`=1) takes its key rights from `user_key_rights`, and only when `mode_ukey` is 1. A supervisor page takes them from `sup_key_rights`, and only when `mode_skey` is 1. A selected value of zero disables key checking.
- R6: For key k, bit 2k of the selected register removes read and write. Otherwise, bit 2k+1 removes write when the access is user or `mode_wp` is 1. Execute is never removed by a key.
- R7: If the key-reduced rights lack the requested access, the error code has bits 5 and 0 set. If only the paging rights lack it, bit 0 alone is set. In both cases the reported permissions are all zero.
- R8: Error code bit 2 is set for user accesses and bit 1 for stores. Bit 4 is set for fetches only when `mode_nxe` or `mode_smep` is 1. Bit 3 is always zero. Access type encodings are: 0 load, 1 store, 2 fetch.
- R9: When `mode_long` is 1, `vaddr[63:47]` must all be equal, or `vaddr[63:56]` when `mode_la57` is 1. Otherwise `fault_gp` is 1, `fault_pf` is 0 and the error code is zero. When `mode_long` is 0, no such check is made.
- R10: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid`=1. Every result output holds its value while `in_valid` is 0.
- R11: `fault_addr` equals the request's `vaddr` on either fault and is zero otherwise. `fault_pf` and `fault_gp` are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| vaddr | input | 64 | Virtual address of the access |
| pg_user | input | 1 | Combined user attribute of the walk |
| pg_write | input | 1 | Combined writable attribute |
| pg_nx | input | 1 | Combined no-execute attribute |
| pg_key | input | 4 | Protection key of the leaf entry |
| acc_priv | input | 2 | 0 user, 1 supervisor, 2 supervisor with user pages blocked |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch |
| mode_wp | input | 1 | Supervisor write protection enable |
| mode_nxe | input | 1 | Execute-disable enable |
| mode_smep | input | 1 | Supervisor fetch from user pages blocked |
| mode_ukey | input | 1 | Keys for user pages enabled |
| mode_skey | input | 1 | Keys for supervisor pages enabled |
| mode_long | input | 1 | 64-bit addressing active |
| mode_la57 | input | 1 | 5-level paging (57-bit addresses) |
| user_key_rights | input | 32 | Key rights for user pages, 2 bits per key |
| sup_key_rights | input | 32 | Key rights for supervisor pages, 2 bits per key |
| out_valid | output | 1 | Result strobe |
| perm_r | output | 1 | Read granted |
| perm_w | output | 1 | Write granted |
| perm_x | output | 1 | Execute granted |
| fault_pf | output | 1 | Page fault |
| fault_gp | output | 1 | General-protection fault |
| err_code | output | 6 | Page-fault error code: bit0 present, 1 write, 2 user, 3 reserved, 4 fetch, 5 key |
| fault_addr | output | 64 | Faulting virtual address |

## Verification
The assertions assume that `acc_type` never carries the unused encoding 3 and `acc_priv` never carries 3. The bench uses only the listed encodings in its vector table and its directed tests. The assertions also take the request fields to be stable only in a cycle where `in_valid` is high. The bench changes them freely in idle cycles, precisely to show that the registered results ignore them there. Key-rights values are arbitrary 32-bit patterns, so the assertions do not depend on any relation between the two registers.

// File: rtl/prc_pkg.sv
package prc_pkg;
  typedef enum logic [1:0] {
    PRIV_USER    = 2'd0,
    PRIV_SUP     = 2'd1,
    PRIV_SUP_NOU = 2'd2
  } priv_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } rights_t;

  localparam int EC_W   = 6;
  localparam int EC_P   = 0;
  localparam int EC_WR  = 1;
  localparam int EC_US  = 2;
  localparam int EC_RSV = 3;
  localparam int EC_ID  = 4;
  localparam int EC_PK  = 5;

  function automatic logic wants(rights_t rt, acc_e a);
    case (a)
      ACC_STORE: wants = rt.w;
      ACC_FETCH: wants = rt.x;
      default:   wants = rt.r;
    endcase
  endfunction
endpackage

// File: rtl/prc_canon.sv
module prc_canon #(
  parameter int VA_W   = 64,
  parameter int LO_TOP = 47,
  parameter int HI_TOP = 56
) (
  input  logic [VA_W-1-LO_TOP:0] va_hi,
  input  logic                   long_en,
  input  logic                   la57_en,
  output logic                   bad
);
  localparam int LO_N = VA_W - LO_TOP;
  localparam int HI_N = VA_W - HI_TOP;

  logic [LO_N-1:0] lo_bits;
  logic [HI_N-1:0] hi_bits;
  logic            lo_ok, hi_ok;

  assign lo_bits = va_hi;
  assign hi_bits = va_hi[LO_N-1 -: HI_N];
  assign lo_ok   = (&lo_bits) | ~(|lo_bits);
  assign hi_ok   = (&hi_bits) | ~(|hi_bits);

  always_comb begin
    if (!long_en)     bad = 1'b0;
    else if (la57_en) bad = !hi_ok;
    else              bad = !lo_ok;
  end
endmodule

// File: rtl/prc_base_rights.sv
module prc_base_rights
  import prc_pkg::*;
(
  input  priv_e   priv,
  input  logic    pg_user,
  input  logic    pg_write,
  input  logic    pg_nx,
  input  logic    wp_en,
  input  logic    smep_en,
  output logic    user_block,
  output rights_t rights
);
  logic is_user;
  logic sup_user_read_blocked;
  logic smep_blocks;

  assign is_user               = (priv == PRIV_USER);
  assign sup_user_read_blocked = (priv == PRIV_SUP_NOU) && pg_user;
  assign smep_blocks           = !is_user && smep_en && pg_user;
  assign user_block            = is_user && !pg_user;

  always_comb begin
    rights.r = !sup_user_read_blocked;
    rights.w = rights.r && (pg_write || (!is_user && !wp_en));
    rights.x = !pg_nx && !smep_blocks;
  end

  // p_write_needs_read_r3: write is never granted without read
  always_comb p_write_needs_read_r3: assert (!(rights.w && !rights.r));
endmodule

// File: rtl/prc_key_rights.sv
module prc_key_rights
  import prc_pkg::*;
#(
  parameter int KEY_W = 4,
  parameter int KR_W  = 2 * (1 << KEY_W)
) (
  input  logic [KEY_W-1:0] key,
  input  logic             pg_user,
  input  logic             is_user,
  input  logic             wp_en,
  input  logic             ukey_en,
  input  logic             skey_en,
  input  logic [KR_W-1:0]  ukr,
  input  logic [KR_W-1:0]  skr,
  output logic             active,
  output rights_t          rights
);
  localparam int NKEYS = 1 << KEY_W;

  logic [KR_W-1:0]  sel;
  logic [NKEYS-1:0] ad_vec;
  logic [NKEYS-1:0] wd_vec;
  logic             ad, wd;

  always_comb begin
    if (pg_user) sel = ukey_en ? ukr : '0;
    else         sel = skey_en ? skr : '0;
  end

  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    assign ad_vec[k] = sel[2*k];
    assign wd_vec[k] = sel[2*k+1];
  end

  assign active = |sel;
  assign ad     = ad_vec[key];
  assign wd     = wd_vec[key];

  always_comb begin
    rights = '{x: 1'b1, w: 1'b1, r: 1'b1};
    if (active) begin
      if (ad) begin
        rights.r = 1'b0;
        rights.w = 1'b0;
      end else if (wd && (is_user || wp_en)) begin
        rights.w = 1'b0;
      end
    end
  end

  // p_ad_blocks_r6: an access-disabled key leaves neither read nor write
  always_comb p_ad_blocks_r6: assert (!(active && ad) || (!rights.r && !rights.w));
  // p_idle_full_r5: without a selected register the key rights are complete
  always_comb p_idle_full_r5: assert (active || (rights.r && rights.w && rights.x));
endmodule

// File: rtl/prc_fault_enc.sv
module prc_fault_enc
  import prc_pkg::*;
(
  input  acc_e            acc,
  input  priv_e           priv,
  input  logic            nxe_en,
  input  logic            smep_en,
  input  logic            gp,
  input  logic            user_block,
  input  logic            key_active,
  input  rights_t         key_rt,
  input  rights_t         base_rt,
  output logic            pf,
  output logic            gpf,
  output logic [EC_W-1:0] code,
  output rights_t         rights
);
  logic [EC_W-1:0] ctx;
  logic            key_deny, base_deny;
  rights_t         merged;

  always_comb begin
    ctx = '0;
    ctx[EC_US] = (priv == PRIV_USER);
    ctx[EC_WR] = (acc == ACC_STORE);
    ctx[EC_ID] = (acc == ACC_FETCH) && (nxe_en || smep_en);
  end

  assign merged    = key_active ? (base_rt & key_rt) : base_rt;
  assign key_deny  = key_active && !wants(key_rt, acc);
  assign base_deny = !wants(merged, acc);

  always_comb begin
    pf     = 1'b0;
    gpf    = 1'b0;
    code   = '0;
    rights = '0;
    if (gp) begin
      gpf = 1'b1;
    end else if (user_block) begin
      pf = 1'b1;
      code = ctx;
      code[EC_P] = 1'b1;
    end else if (key_deny) begin
      pf = 1'b1;
      code = ctx;
      code[EC_P]  = 1'b1;
      code[EC_PK] = 1'b1;
    end else if (base_deny) begin
      pf = 1'b1;
      code = ctx;
      code[EC_P] = 1'b1;
    end else begin
      rights = merged;
    end
  end

  // p_pk_has_p_r7: a key fault always carries the present bit
  always_comb p_pk_has_p_r7: assert (!code[EC_PK] || code[EC_P]);
  // p_rsv_clear_r8: the reserved bit is never produced here
  always_comb p_rsv_clear_r8: assert (!code[EC_RSV] || !pf);
endmodule

// File: rtl/page_rights_checker.sv
module page_rights_checker
  import prc_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int LO_TOP = 47,
  parameter int HI_TOP = 56,
  parameter int KEY_W  = 4,
  parameter int KR_W   = 2 * (1 << KEY_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             pg_user,
  input  logic             pg_write,
  input  logic             pg_nx,
  input  logic [KEY_W-1:0] pg_key,
  input  logic [1:0]       acc_priv,
  input  logic [1:0]       acc_type,
  input  logic             mode_wp,
  input  logic             mode_nxe,
  input  logic             mode_smep,
  input  logic             mode_ukey,
  input  logic             mode_skey,
  input  logic             mode_long,
  input  logic             mode_la57,
  input  logic [KR_W-1:0]  user_key_rights,
  input  logic [KR_W-1:0]  sup_key_rights,
  output logic             out_valid,
  output logic             perm_r,
  output logic             perm_w,
  output logic             perm_x,
  output logic             fault_pf,
  output logic             fault_gp,
  output logic [EC_W-1:0]  err_code,
  output logic [VA_W-1:0]  fault_addr
);
  priv_e           priv;
  acc_e            acc;
  logic            is_user;
  logic            gp_bad;
  logic            user_block;
  rights_t         base_rt, key_rt, fin_rt;
  logic            key_active;
  logic            pf_c, gp_c;
  logic [EC_W-1:0] code_c;

  assign priv    = priv_e'(acc_priv);
  assign acc     = acc_e'(acc_type);
  assign is_user = (priv == PRIV_USER);

  prc_canon #(.VA_W(VA_W), .LO_TOP(LO_TOP), .HI_TOP(HI_TOP)) u_canon (
    .va_hi   (vaddr[VA_W-1:LO_TOP]),
    .long_en (mode_long),
    .la57_en (mode_la57),
    .bad     (gp_bad)
  );

  prc_base_rights u_base (
    .priv       (priv),
    .pg_user    (pg_user),
    .pg_write   (pg_write),
    .pg_nx      (pg_nx),
    .wp_en      (mode_wp),
    .smep_en    (mode_smep),
    .user_block (user_block),
    .rights     (base_rt)
  );

  prc_key_rights #(.KEY_W(KEY_W), .KR_W(KR_W)) u_key (
    .key     (pg_key),
    .pg_user (pg_user),
    .is_user (is_user),
    .wp_en   (mode_wp),
    .ukey_en (mode_ukey),
    .skey_en (mode_skey),
    .ukr     (user_key_rights),
    .skr     (sup_key_rights),
    .active  (key_active),
    .rights  (key_rt)
  );

  prc_fault_enc u_enc (
    .acc        (acc),
    .priv       (priv),
    .nxe_en     (mode_nxe),
    .smep_en    (mode_smep),
    .gp         (gp_bad),
    .user_block (user_block),
    .key_active (key_active),
    .key_rt     (key_rt),
    .base_rt    (base_rt),
    .pf         (pf_c),
    .gpf        (gp_c),
    .code       (code_c),
    .rights     (fin_rt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      perm_r     <= 1'b0;
      perm_w     <= 1'b0;
      perm_x     <= 1'b0;
      fault_pf   <= 1'b0;
      fault_gp   <= 1'b0;
      err_code   <= '0;
      fault_addr <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        perm_r     <= fin_rt.r;
        perm_w     <= fin_rt.w;
        perm_x     <= fin_rt.x;
        fault_pf   <= pf_c;
        fault_gp   <= gp_c;
        err_code   <= code_c;
        fault_addr <= (pf_c || gp_c) ? vaddr : '0;
      end
    end
  end

  p_valid_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(err_code) && $stable(fault_pf) && $stable(perm_w)));
  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(fault_pf && fault_gp));
  p_noperm_r7: assert property (@(posedge clk) disable iff (rst)
    (fault_pf || fault_gp) |-> !(perm_r || perm_w || perm_x));
  p_gp_code_r9: assert property (@(posedge clk) disable iff (rst)
    fault_gp |-> (err_code == '0));
  p_ubit_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (!fault_pf || (err_code[EC_US] == ($past(acc_priv) == 2'd0))));
  p_user_first_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode_long && acc_priv == 2'd0 && !pg_user)
      |=> (fault_pf && !err_code[EC_PK]));
endmodule

// File: tb/sim_page_rights_checker.sv
`timescale 1ns/1ps
module sim_page_rights_checker;
  typedef struct packed {
    logic [1:0]  priv;
    logic [1:0]  acc;
    logic        u, w, nx;
    logic [3:0]  key;
    logic        wp, nxe, smep, uke, ske;
    logic [31:0] ukr, skr;
    logic        e_pf;
    logic [2:0]  e_perm;   // {x,w,r}
    logic [5:0]  e_code;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam logic [63:0] VA0 = 64'h0000_7fff_dead_b000;
  // fields: priv acc u w nx key wp nxe smep uke ske ukr skr | pf perm code req
  localparam vec_t TAB [NV] = '{
    '{2'd0,2'd0,1,1,0,4'd0,0,0,0,0,0,32'h0,32'h0, 0,3'b111,6'h00,4'd2}, // R2 R3 R4 user rw page
    '{2'd0,2'd0,0,1,0,4'd0,0,0,0,0,0,32'h0,32'h0, 1,3'b000,6'h05,4'd1}, // R1
    '{2'd0,2'd1,0,1,0,4'd0,0,1,0,0,0,32'h0,32'h0, 1,3'b000,6'h07,4'd8}, // R8 store bit
    '{2'd0,2'd2,0,1,0,4'd0,0,0,0,0,0,32'h0,32'h0, 1,3'b000,6'h05,4'd8}, // R8 fetch bit gated off
    '{2'd0,2'd2,0,1,0,4'd0,0,1,0,0,0,32'h0,32'h0, 1,3'b000,6'h15,4'd8}, // R8 fetch bit with nxe
    '{2'd1,2'd1,0,0,0,4'd0,0,0,0,0,0,32'h0,32'h0, 0,3'b111,6'h00,4'd3}, // R3 sup write, wp off
    '{2'd1,2'd1,0,0,0,4'd0,1,0,0,0,0,32'h0,32'h0, 1,3'b000,6'h03,4'd3}, // R3 wp on
    '{2'd2,2'd0,1,1,0,4'd0,0,0,0,0,0,32'h0,32'h0, 1,3'b000,6'h01,4'd2}, // R2 blocked
    '{2'd2,2'd0,0,1,0,4'd0,0,0,0,0,0,32'h0,32'h0, 0,3'b111,6'h00,4'd2}, // R2 sup page ok
    '{2'd1,2'd2,1,1,0,4'd0,0,0,1,0,0,32'h0,32'h0, 1,3'b000,6'h11,4'd4}, // R4 smep
    '{2'd1,2'd2,0,1,1,4'd0,0,1,0,0,0,32'h0,32'h0, 1,3'b000,6'h11,4'd4}, // R4 nx
    '{2'd0,2'd2,1,0,0,4'd0,0,0,1,0,0,32'h0,32'h0, 0,3'b101,6'h00,4'd4}, // R4 user ignores smep
    '{2'd0,2'd0,1,1,0,4'd3,0,0,0,1,0,32'h40,32'h0, 1,3'b000,6'h25,4'd6}, // R6 AD
    '{2'd0,2'd2,1,1,0,4'd3,0,0,0,1,0,32'h40,32'h0, 0,3'b100,6'h00,4'd6}, // R6 AD keeps exec
    '{2'd0,2'd1,1,1,0,4'd3,0,0,0,1,0,32'h80,32'h0, 1,3'b000,6'h27,4'd6}, // R6 WD user
    '{2'd0,2'd0,1,1,0,4'd3,0,0,0,1,0,32'h80,32'h0, 0,3'b101,6'h00,4'd6}, // R6 WD load
    '{2'd1,2'd1,0,1,0,4'd2,0,0,0,0,1,32'h0,32'h20, 0,3'b111,6'h00,4'd6}, // R6 WD sup wp off
    '{2'd1,2'd1,0,1,0,4'd2,1,0,0,0,1,32'h0,32'h20, 1,3'b000,6'h23,4'd6}, // R6 WD sup wp on
    '{2'd0,2'd0,1,1,0,4'd3,0,0,0,0,0,32'h40,32'h0, 0,3'b111,6'h00,4'd5}, // R5 user keys off
    '{2'd1,2'd0,0,1,0,4'd3,0,0,0,1,1,32'h40,32'h0, 0,3'b111,6'h00,4'd5}, // R5 sup page zero reg
    '{2'd0,2'd0,1,0,0,4'd1,0,0,0,1,0,32'hFFFFFFF3,32'h0, 0,3'b101,6'h00,4'd5}, // R5 key index
    '{2'd1,2'd0,1,1,0,4'd0,0,0,0,1,0,32'h1,32'h0, 1,3'b000,6'h21,4'd7}, // R7 key fault sup
    '{2'd0,2'd1,1,0,0,4'd3,0,0,0,1,0,32'h80,32'h0, 1,3'b000,6'h27,4'd7}, // R7 key wins
    '{2'd0,2'd1,1,0,0,4'd0,0,0,0,0,0,32'h0,32'h0, 1,3'b000,6'h07,4'd7}, // R7 paging only
    '{2'd0,2'd0,0,1,0,4'd0,0,0,0,0,1,32'h0,32'h1, 1,3'b000,6'h05,4'd1}  // R1 before key
  };

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [63:0] vaddr = '0;
  logic pg_user = 0, pg_write = 0, pg_nx = 0;
  logic [3:0] pg_key = '0;
  logic [1:0] acc_priv = '0, acc_type = '0;
  logic mode_wp = 0, mode_nxe = 0, mode_smep = 0, mode_ukey = 0, mode_skey = 0;
  logic mode_long = 0, mode_la57 = 0;
  logic [31:0] user_key_rights = '0, sup_key_rights = '0;
  logic out_valid, perm_r, perm_w, perm_x, fault_pf, fault_gp;
  logic [5:0] err_code;
  logic [63:0] fault_addr;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  page_rights_checker u0 (.*);

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load(input vec_t v, input logic [63:0] a, input logic lng, input logic l57);
    vaddr = a; pg_user = v.u; pg_write = v.w; pg_nx = v.nx; pg_key = v.key;
    acc_priv = v.priv; acc_type = v.acc; mode_wp = v.wp; mode_nxe = v.nxe;
    mode_smep = v.smep; mode_ukey = v.uke; mode_skey = v.ske;
    user_key_rights = v.ukr; sup_key_rights = v.skr;
    mode_long = lng; mode_la57 = l57;
  endtask

  task automatic fire();
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic vec_t plain_user();
    vec_t v = '0;
    v.priv = 2'd0; v.u = 1; v.w = 1;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10", "reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R11", "reset faults", {62'd0, fault_pf, fault_gp}, 64'd0);
    chk("R10", "reset perms", {61'd0, perm_x, perm_w, perm_r}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d[v%0d]", TAB[i].req, i);
      load(TAB[i], VA0, 1'b0, 1'b0);
      fire();
      chk(rq, "valid", {63'd0, out_valid}, 64'd1);
      chk(rq, "pf", {63'd0, fault_pf}, {63'd0, TAB[i].e_pf});
      chk(rq, "perm", {61'd0, perm_x, perm_w, perm_r}, {61'd0, TAB[i].e_perm});
      chk(rq, "code", {58'd0, err_code}, {58'd0, TAB[i].e_code});
      chk(rq, "addr", fault_addr, TAB[i].e_pf ? VA0 : 64'd0);
    end

    // R9 canonical checks
    load(plain_user(), 64'h0000_8000_0000_0000, 1'b1, 1'b0);
    fire();
    chk("R9", "gp 48-bit", {62'd0, fault_gp, fault_pf}, 64'd2);
    chk("R9", "gp code", {58'd0, err_code}, 64'd0);
    chk("R11", "gp addr", fault_addr, 64'h0000_8000_0000_0000);
    load(plain_user(), 64'hFFFF_8000_0000_1000, 1'b1, 1'b0);
    fire();
    chk("R9", "canonical high", {59'd0, fault_gp, fault_pf, perm_x, perm_w, perm_r}, 64'h7);
    load(plain_user(), 64'h0000_8000_0000_0000, 1'b1, 1'b1);
    fire();
    chk("R9", "la57 accepts", {59'd0, fault_gp, fault_pf, perm_x, perm_w, perm_r}, 64'h7);
    load(plain_user(), 64'h0100_0000_0000_0000, 1'b1, 1'b1);
    fire();
    chk("R9", "la57 gp", {62'd0, fault_gp, fault_pf}, 64'd2);
    load(plain_user(), 64'h1234_0000_0000_0000, 1'b0, 1'b0);
    fire();
    chk("R9", "no check out of long mode", {62'd0, fault_gp, fault_pf}, 64'd0);
    begin
      vec_t v = plain_user();
      v.u = 0;
      load(v, 64'h0000_8000_0000_0000, 1'b1, 1'b0);
      fire();
      chk("R9", "gp before user check", {62'd0, fault_gp, fault_pf}, 64'd2);
    end

    // R10 timing and hold
    load(plain_user(), VA0, 1'b0, 1'b0);
    fire();
    chk("R10", "strobe", {63'd0, out_valid}, 64'd1);
    acc_priv = 2'd0; pg_user = 1'b0; acc_type = 2'd1;
    @(negedge clk);
    chk("R10", "single pulse", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    chk("R10", "hold perms", {59'd0, fault_gp, fault_pf, perm_x, perm_w, perm_r}, 64'h7);
    chk("R10", "hold code", {58'd0, err_code}, 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule